// File: doc/BRIEF.md
# Shared Bus Arbiter with Selectable Priority

This block shares one single-clock bus among a set of masters (sixteen by default). Each master has its own request line and its own hold line, and receives its own grant line. At every arbitration point the arbiter chooses one requester, using either fixed index order or least-recently-granted order, as picked by a run-time mode pin. The grant is registered, so a master sees it one cycle after the decision. The owner keeps the bus for as long as its hold line stays high. When the owner drops its hold line, the bus is released on that edge and a new owner is chosen on the same edge.

The shared address, write-data and control lanes are built as AND-OR trees. Each master's fields are ANDed with its own grant bit, and the results are ORed together, so every source that is not granted contributes zeros. The slaves' read-data vectors are combined by the same OR scheme. Each slave must drive zeros while it is not selected. The interface is plain control: there is no valid/ready stage, and no back-pressure exists beyond a requester waiting for its grant.

Top module: `bus_arbiter`

## Requirements
- R1: After reset, no grant is asserted, all shared bus lanes are zero, and the least-recently-granted order is index order, with master 0 the most preferred.
- R2: At most one grant bit is high in any cycle.
- R3: When no master is holding the bus, the grant in the next cycle goes to one of the masters requesting in this cycle. If no master is requesting, the next grant is all zero.
- R4: With the mode pin at 0 (fixed), the lowest-indexed requester wins each arbitration.
- R5: With the mode pin at 1 (least recently used), the requester that was granted longest ago wins. Every arbitration that issues a grant, in either mode, moves the chosen master to the most-recent end of the order.
- R6: While the current owner keeps its hold line high, its grant stays unchanged. During that time, requests from other masters, the owner's own request and the mode pin have no effect, and the order is not updated.
- R7: On the edge at which the owner's hold line is low, a new arbitration takes place among the current requests, using the mode present at that edge.
- R8: The shared address, write-data and control lanes equal the granted master's fields. They are all zero when no grant is asserted.
- R9: The shared read-data lane is the bitwise OR of all slave read-data vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prio_mode | input | 1 | 0 = fixed index priority, 1 = least-recently-granted priority |
| m_req | input | NUM_M | Per-master request |
| m_hold | input | NUM_M | Per-master bus hold (lock) line |
| m_addr | input | NUM_M*AW | Per-master address, master i at bits i*AW upward |
| m_wdata | input | NUM_M*DW | Per-master write data, same packing |
| m_ctrl | input | NUM_M*CW | Per-master control qualifiers, same packing |
| s_rdata | input | NUM_S*DW | Per-slave read data, zero when the slave is idle |
| m_grant | output | NUM_M | Registered one-hot-or-zero grant |
| bus_addr | output | AW | Shared address lane |
| bus_wdata | output | DW | Shared write-data lane |
| bus_ctrl | output | CW | Shared control lane |
| bus_rdata | output | DW | Shared read-data lane |

## Verification
The bench builds the arbiter with five masters, three slaves and 32-bit address and data. With five masters, every reordering of the least-recently-granted list can be worked out by hand and reached within a few dozen cycles. This includes the cases where the chosen master sits at the front, in the middle or at the end of the list. The run also toggles the mode while a hold is in force and releases the hold into a full set of requests. It covers an owner that keeps the bus with its request low, and read data ORed from two active slaves.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic {
    PRIO_FIXED = 1'b0,
    PRIO_LRU   = 1'b1
  } prio_mode_e;

endpackage

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick #(
  parameter int NUM = 16
) (
  input  logic [NUM-1:0] req,
  output logic [NUM-1:0] pick
);

  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < NUM; i++) begin
      if (!found && req[i]) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/arb_lru_order.sv
module arb_lru_order #(
  parameter int NUM = 16,
  localparam int IW = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] req,
  input  logic           upd_en,
  input  logic [IW-1:0]  upd_idx,
  output logic [NUM-1:0] pick
);

  // ord_q[0] is the most preferred (least recently granted) master
  logic [IW-1:0] ord_q [NUM];
  logic [IW-1:0] ord_d [NUM];
  logic [IW-1:0] pos;

  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int p = 0; p < NUM; p++) begin
      if (!found && req[ord_q[p]]) begin
        pick[ord_q[p]] = 1'b1;
        found          = 1'b1;
      end
    end
  end

  always_comb begin
    pos = '0;
    for (int p = 0; p < NUM; p++) begin
      if (ord_q[p] == upd_idx) pos = IW'(p);
    end
  end

  always_comb begin
    for (int p = 0; p < NUM - 1; p++) begin
      ord_d[p] = (p < int'(pos)) ? ord_q[p] : ord_q[p+1];
    end
    ord_d[NUM-1] = upd_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM; p++) ord_q[p] <= IW'(p);
    end else if (upd_en) begin
      for (int p = 0; p < NUM; p++) ord_q[p] <= ord_d[p];
    end
  end

  // the order must always remain a permutation of the master indices
  logic [NUM-1:0] seen;
  always_comb begin
    seen = '0;
    for (int p = 0; p < NUM; p++) seen[ord_q[p]] = 1'b1;
  end

  assert_order_perm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seen == {NUM{1'b1}});

  assert_lru_pick_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pick & ~req) == '0);

endmodule

// File: rtl/arb_andor_mux.sv
module arb_andor_mux #(
  parameter int NUM = 16,
  parameter int W   = 32
) (
  input  logic [NUM*W-1:0] src,
  input  logic [NUM-1:0]   sel,
  output logic [W-1:0]     out
);

  always_comb begin
    out = '0;
    for (int i = 0; i < NUM; i++) begin
      out = out | (src[i*W +: W] & {W{sel[i]}});
    end
  end

endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_M = 16,
  parameter int NUM_S = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 4,
  localparam int IW   = (NUM_M > 1) ? $clog2(NUM_M) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prio_mode,
  input  logic [NUM_M-1:0]   m_req,
  input  logic [NUM_M-1:0]   m_hold,
  input  logic [NUM_M*AW-1:0] m_addr,
  input  logic [NUM_M*DW-1:0] m_wdata,
  input  logic [NUM_M*CW-1:0] m_ctrl,
  input  logic [NUM_S*DW-1:0] s_rdata,
  output logic [NUM_M-1:0]   m_grant,
  output logic [AW-1:0]      bus_addr,
  output logic [DW-1:0]      bus_wdata,
  output logic [CW-1:0]      bus_ctrl,
  output logic [DW-1:0]      bus_rdata
);

  prio_mode_e       mode_sel;
  logic [NUM_M-1:0] gnt_q, gnt_d;
  logic [NUM_M-1:0] fixed_pick, lru_pick, arb_pick;
  logic             owner_hold;
  logic             upd_en;
  logic [IW-1:0]    upd_idx;

  assign mode_sel   = prio_mode_e'(prio_mode);
  assign owner_hold = |(gnt_q & m_hold);

  arb_fixed_pick #(.NUM(NUM_M)) u_fixed (
    .req  (m_req),
    .pick (fixed_pick)
  );

  arb_lru_order #(.NUM(NUM_M)) u_lru (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (m_req),
    .upd_en  (upd_en),
    .upd_idx (upd_idx),
    .pick    (lru_pick)
  );

  // the mode is consulted only when the bus is free to change hands
  assign arb_pick = (mode_sel == PRIO_LRU) ? lru_pick : fixed_pick;
  assign gnt_d    = owner_hold ? gnt_q : arb_pick;
  assign upd_en   = !owner_hold && (|arb_pick);

  always_comb begin
    upd_idx = '0;
    for (int i = 0; i < NUM_M; i++) begin
      if (arb_pick[i]) upd_idx = IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gnt_q <= '0;
    else        gnt_q <= gnt_d;
  end

  assign m_grant = gnt_q;

  // shared master lanes: one AND-OR tree per field width
  localparam int NLANE = 3;
  localparam int LW [NLANE] = '{AW, DW, CW};

  generate
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
      logic [NUM_M*LW[g]-1:0] lane_src;
      logic [LW[g]-1:0]       lane_out;
      if (g == 0) begin : g_a
        assign lane_src = m_addr;
        assign bus_addr = lane_out;
      end else if (g == 1) begin : g_w
        assign lane_src  = m_wdata;
        assign bus_wdata = lane_out;
      end else begin : g_c
        assign lane_src = m_ctrl;
        assign bus_ctrl = lane_out;
      end
      arb_andor_mux #(.NUM(NUM_M), .W(LW[g])) u_mux (
        .src (lane_src),
        .sel (gnt_q),
        .out (lane_out)
      );
    end
  endgenerate

  // slave return: every idle slave drives zero, so all selects are open
  arb_andor_mux #(.NUM(NUM_S), .W(DW)) u_rmux (
    .src (s_rdata),
    .sel ({NUM_S{1'b1}}),
    .out (bus_rdata)
  );

  assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_grant));

  assert_grant_from_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !owner_hold |=> ((m_grant & ~$past(m_req)) == '0));

  assert_idle_when_no_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!owner_hold && m_req == '0) |=> (m_grant == '0));

  assert_fixed_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!owner_hold && mode_sel == PRIO_FIXED)
      |=> (m_grant == ($past(m_req) & (~$past(m_req) + 1'b1))));

  assert_hold_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    owner_hold |=> $stable(m_grant));

  assert_idle_lanes_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_grant == '0) |-> (bus_addr == '0 && bus_wdata == '0 && bus_ctrl == '0));

endmodule

// File: tb/test_bus_arbiter.sv
`timescale 1ns/1ps
module test_bus_arbiter;

  localparam int NM = 5;
  localparam int NS = 3;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 4;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               prio_mode = 1'b0;
  logic [NM-1:0]      m_req = '0;
  logic [NM-1:0]      m_hold = '0;
  logic [NM*AW-1:0]   m_addr;
  logic [NM*DW-1:0]   m_wdata;
  logic [NM*CW-1:0]   m_ctrl;
  logic [NS*DW-1:0]   s_rdata = '0;
  logic [NM-1:0]      m_grant;
  logic [AW-1:0]      bus_addr;
  logic [DW-1:0]      bus_wdata;
  logic [CW-1:0]      bus_ctrl;
  logic [DW-1:0]      bus_rdata;

  always #2.5 clk = ~clk;

  bus_arbiter #(.NUM_M(NM), .NUM_S(NS), .AW(AW), .DW(DW), .CW(CW)) i_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .prio_mode(prio_mode),
    .m_req(m_req), .m_hold(m_hold),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_ctrl(m_ctrl),
    .s_rdata(s_rdata), .m_grant(m_grant),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ctrl(bus_ctrl),
    .bus_rdata(bus_rdata)
  );

  function automatic logic [AW-1:0] addr_of(int i);
    return 32'h1000_0000 + 32'(i) * 32'h0000_0111;
  endfunction
  function automatic logic [DW-1:0] wdata_of(int i);
    return ~addr_of(i);
  endfunction
  function automatic logic [CW-1:0] ctrl_of(int i);
    return CW'(i + 1);
  endfunction

  initial begin
    for (int i = 0; i < NM; i++) begin
      m_addr[i*AW +: AW]  = addr_of(i);
      m_wdata[i*DW +: DW] = wdata_of(i);
      m_ctrl[i*CW +: CW]  = ctrl_of(i);
    end
  end

  typedef struct {
    logic [NM-1:0] gnt;
    logic [DW-1:0] rdata;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  task automatic check_val(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push the expected result
  task automatic step(logic mode, logic [NM-1:0] req, logic [NM-1:0] hold,
                      logic [NM-1:0] exp_g, string tag,
                      logic [DW-1:0] s0 = '0, logic [DW-1:0] s1 = '0,
                      logic [DW-1:0] s2 = '0);
    exp_t e;
    @(negedge clk);
    prio_mode = mode;
    m_req     = req;
    m_hold    = hold;
    s_rdata   = {s2, s1, s0};
    e.gnt   = exp_g;
    e.rdata = s0 | s1 | s2;
    e.tag   = tag;
    exp_q.push_back(e);
    @(posedge clk);
  endtask

  // monitor: compare after each edge against the scoreboard
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      logic [AW-1:0] ea;
      logic [DW-1:0] ew;
      logic [CW-1:0] ec;
      e  = exp_q.pop_front();
      ea = '0; ew = '0; ec = '0;
      for (int i = 0; i < NM; i++) begin
        if (e.gnt[i]) begin
          ea = addr_of(i); ew = wdata_of(i); ec = ctrl_of(i);
        end
      end
      check_val({e.tag, " grant"}, 64'(m_grant), 64'(e.gnt));
      check_val("R2 single grant", 64'($countones(m_grant) <= 1), 64'(1));
      check_val("R8 addr lane", 64'(bus_addr), 64'(ea));
      check_val("R8 wdata lane", 64'(bus_wdata), 64'(ew));
      check_val("R8 ctrl lane", 64'(bus_ctrl), 64'(ec));
      check_val("R9 rdata OR", 64'(bus_rdata), 64'(e.rdata));
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_val("R1 reset grant", 64'(m_grant), 64'(0));
    check_val("R1 reset addr lane", 64'(bus_addr), 64'(0));
    check_val("R1 reset ctrl lane", 64'(bus_ctrl), 64'(0));

    // R1 and R5: the initial order is index order, so m2 wins among {2,3,4}
    step(1'b1, 5'b11100, 5'b00000, 5'b00100, "R1 initial lru order");
    // R4 fixed priority
    step(1'b0, 5'b00110, 5'b00000, 5'b00010, "R4 fixed lowest", 32'h0000_00F0);
    step(1'b0, 5'b00110, 5'b00000, 5'b00010, "R4 fixed repeat");
    // R3 no requests
    step(1'b0, 5'b00000, 5'b00000, 5'b00000, "R3 no request", 32'hA5A5_0000, 32'h0000_5A5A);
    // R5 least recently used walk; order [0,3,4,2,1]
    step(1'b1, 5'b10110, 5'b00000, 5'b10000, "R5 lru pick m4");
    step(1'b1, 5'b10110, 5'b00000, 5'b00100, "R5 lru pick m2");
    step(1'b1, 5'b10110, 5'b00000, 5'b00010, "R5 lru pick m1", '0, '0, 32'h1234_5678);
    step(1'b1, 5'b11111, 5'b00000, 5'b00001, "R5 lru pick m0");
    step(1'b1, 5'b00001, 5'b00000, 5'b00001, "R5 lru sole m0");
    step(1'b1, 5'b01001, 5'b00000, 5'b01000, "R5 lru pick m3");
    // R6 hold, with mode toggled and other requests ignored
    step(1'b1, 5'b00010, 5'b00010, 5'b00010, "R5 lru pick m1 with hold");
    step(1'b0, 5'b11111, 5'b00010, 5'b00010, "R6 hold ignores requests");
    step(1'b0, 5'b11111, 5'b00010, 5'b00010, "R6 hold ignores mode");
    // R7 release into a full set of requests, fixed mode
    step(1'b0, 5'b11111, 5'b00000, 5'b00001, "R7 release rearbitrates");
    step(1'b1, 5'b00100, 5'b00100, 5'b00100, "R7 non-owner hold ignored");
    step(1'b1, 5'b00000, 5'b00100, 5'b00100, "R6 hold without request");
    // R6: order untouched by held cycles -> [4,3,1,0,2]
    step(1'b1, 5'b11011, 5'b00000, 5'b10000, "R6 order frozen during hold");
    step(1'b0, 5'b11000, 5'b00000, 5'b01000, "R4 fixed after lru");
    // R5: order updated by fixed grants too -> [1,0,2,4,3]
    step(1'b1, 5'b00111, 5'b00000, 5'b00010, "R5 order tracks fixed grants");
    step(1'b0, 5'b00000, 5'b00000, 5'b00000, "R3 idle end");

    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule